// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of five DMA channels may drive the single shared bus master next. Each channel has three inputs. The first is a request line, which is the OR of the hardware handshake requests of the peripherals tied to that channel. The second is an enable bit. The third is a two-bit software priority level. The arbiter issues a one-hot grant, keeps it for one single transfer, and then sends a one-cycle acknowledge back to the requesting channel.

Arbitration has two tiers. The channel with the highest level wins. Among channels with the same level, the lowest channel index wins. A grant stays fixed until the transfer engine raises `xferDone`. After an acknowledge, the same channel cannot be granted again until its request line has been seen low for at least one clock. This enforces the handshake rule that a peripheral must drop its request before it raises a new one. Address generation, data movement and bus timing belong to the transfer engine and are not part of this block.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it, `grant` and `periphAck` are all zeros.
- R2: `grant` is always either zero or one-hot. It is zero when no channel is eligible. A channel is eligible when its request is high, its enable is high, and it is not waiting for its request to drop.
- R3: A channel whose `chEnable` bit is low is never granted, even when its request is asserted and its level is the highest.
- R4: Channel i's level sits in `chLevel[2*i+1:2*i]`. The encoding is 3 = very high, 2 = high, 1 = medium, 0 = low. An eligible channel with a strictly higher level always wins over one with a lower level.
- R5: When eligible channels share the top level, the lowest-numbered of them is granted.
- R6: A grant starts on the clock edge that sees an eligible channel while no grant is held. It then stays unchanged until `xferDone` is sampled high, whatever happens to requests, enables or levels in the meantime.
- R7: `xferDone` has no effect while no grant is held.
- R8: On the edge that samples `xferDone` high during a grant, `grant` returns to zero. On that same edge, `periphAck` pulses high for exactly one cycle on the bit of the channel that was granted.
- R9: Arbitration resumes on the edge right after the acknowledge cycle. A different eligible channel can be granted there.
- R10: After its acknowledge, a channel is not granted again until one clock edge has sampled its request low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chReq | input | 5 | Combined peripheral request per channel |
| chEnable | input | 5 | Channel enable bits |
| chLevel | input | 10 | Two-bit priority level per channel, channel i at bits 2i+1:2i |
| xferDone | input | 1 | Current single transfer has completed |
| grant | output | 5 | One-hot grant to the winning channel |
| periphAck | output | 5 | One-cycle acknowledge to the served channel |

## Verification
The bench pits channels with the same level against each other, so that a design that picks the highest index would grant the wrong channel. It also pits a low-index channel against a higher-index channel with a higher level, so that a design that compares by index alone fails. Requests, levels and enables are changed in the middle of a grant; a design that re-arbitrates before `xferDone` would switch channels there. The bench keeps a served request held high through the cycles after its acknowledge. A design without the wait-for-drop mask would grant that same channel again straight away. The bench also asserts `xferDone` while no grant is held, and an arbiter that acts on that stray done would emit an acknowledge.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned NUM_CH = 5;
  localparam int unsigned LVL_W  = 2;

  typedef struct packed {
    logic load;  // capture the winner as the new grant
    logic drop;  // end the grant, acknowledge the channel
  } arbStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arbState_t;
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned LVL_W  = 2
) (
  input  logic [NUM_CH-1:0]       elig,
  input  logic [NUM_CH*LVL_W-1:0] level,
  output logic [NUM_CH-1:0]       winner,
  output logic                    anyElig
);
  logic [LVL_W-1:0] bestLvl;
  logic             found;

  always_comb begin
    winner  = '0;
    bestLvl = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      // ascending scan: strict '>' keeps the lower index on ties
      if (elig[i] && (!found || level[i*LVL_W +: LVL_W] > bestLvl)) begin
        winner    = '0;
        winner[i] = 1'b1;
        bestLvl   = level[i*LVL_W +: LVL_W];
        found     = 1'b1;
      end
    end
    anyElig = found;
  end
endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyElig,
  input  logic       xferDone,
  output arbStrobe_t strobe
);
  arbState_t stateQ, stateD;

  always_comb begin
    stateD      = stateQ;
    strobe.load = 1'b0;
    strobe.drop = 1'b0;
    case (stateQ)
      ST_IDLE: if (anyElig) begin
        strobe.load = 1'b1;
        stateD      = ST_BUSY;
      end
      ST_BUSY: if (xferDone) begin
        strobe.drop = 1'b1;
        stateD      = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R8: a drop is always followed by an idle cycle, never a second drop
  a_r8_single_drop: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drop |=> !strobe.drop);
  // R7: done while idle never produces a drop
  a_r7_idle_done: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE) |-> !strobe.drop);
endmodule

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strobe,
  input  logic [NUM_CH-1:0] chReq,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [NUM_CH-1:0] winner,
  output logic [NUM_CH-1:0] elig,
  output logic [NUM_CH-1:0] grantQ,
  output logic [NUM_CH-1:0] ackQ
);
  logic [NUM_CH-1:0] waitDropQ;

  assign elig = chReq & chEnable & ~waitDropQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ    <= '0;
      ackQ      <= '0;
      waitDropQ <= '0;
    end else begin
      ackQ <= '0;
      if (strobe.load) grantQ <= winner;
      if (strobe.drop) begin
        grantQ <= '0;
        ackQ   <= grantQ;
      end
      // mask clears once the request is seen low; a new ack sets it
      waitDropQ <= (waitDropQ & chReq) | (strobe.drop ? grantQ : '0);
    end
  end

  // R2: grant is zero or one-hot
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantQ));
  // R6: a held grant does not move until done
  a_r6_grant_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((|grantQ) && !strobe.drop) |=> $stable(grantQ));
  // R8: ack is a single-cycle pulse naming the channel granted before it
  a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (|ackQ) |=> (ackQ == '0));
  a_r8_ack_matches: assert property (@(posedge clk) disable iff (!rstN)
    (|ackQ) |-> (ackQ == $past(grantQ)) && (grantQ == '0));
  // R3: a new grant goes to an enabled, requesting channel
  a_r3_grant_enabled: assert property (@(posedge clk) disable iff (!rstN)
    ($past(grantQ) == '0 && grantQ != '0) |-> (($past(chReq & chEnable) & grantQ) != '0));
  // R10: the channel just acknowledged is not granted on the next edge
  a_r10_no_regrant: assert property (@(posedge clk) disable iff (!rstN)
    (|ackQ) |=> ((grantQ & $past(ackQ)) == '0));
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned CH_COUNT = NUM_CH,
  parameter int unsigned LVL_BITS = LVL_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CH_COUNT-1:0]          chReq,
  input  logic [CH_COUNT-1:0]          chEnable,
  input  logic [CH_COUNT*LVL_BITS-1:0] chLevel,
  input  logic                         xferDone,
  output logic [CH_COUNT-1:0]          grant,
  output logic [CH_COUNT-1:0]          periphAck
);
  arbStrobe_t          strobe;
  logic [CH_COUNT-1:0] elig;
  logic [CH_COUNT-1:0] winner;
  logic                anyElig;

  dma_arb_pick #(.NUM_CH(CH_COUNT), .LVL_W(LVL_BITS)) u_pick (
    .elig    (elig),
    .level   (chLevel),
    .winner  (winner),
    .anyElig (anyElig)
  );

  dma_arb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyElig  (anyElig),
    .xferDone (xferDone),
    .strobe   (strobe)
  );

  dma_arb_datapath #(.NUM_CH(CH_COUNT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .chReq    (chReq),
    .chEnable (chEnable),
    .winner   (winner),
    .elig     (elig),
    .grantQ   (grant),
    .ackQ     (periphAck)
  );
endmodule

// File: tb/test_dma_chan_arbiter.sv
module test_dma_chan_arbiter;
  logic       clk = 1'b0;
  logic       rstN;
  logic [4:0] chReq, chEnable, grant, periphAck;
  logic [9:0] chLevel;
  logic       xferDone;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [4:0] g;
    logic [4:0] a;
    string      tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #2 clk = ~clk;

  dma_chan_arbiter i_dma_chan_arbiter (
    .clk(clk), .rstN(rstN), .chReq(chReq), .chEnable(chEnable),
    .chLevel(chLevel), .xferDone(xferDone), .grant(grant), .periphAck(periphAck)
  );

  task automatic cmp(input logic [4:0] act, input logic [4:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // driver: set inputs away from the edge, push what the next edge must show
  task automatic cyc(input logic [4:0] req, input logic [4:0] en, input logic done,
                     input logic [4:0] expG, input logic [4:0] expA, input string tag);
    expItem_t it;
    @(negedge clk);
    chReq = req; chEnable = en; xferDone = done;
    it.g = expG; it.a = expA; it.tag = tag;
    sbQ.push_back(it);
  endtask

  function automatic logic [9:0] lv(input int l4, input int l3, input int l2, input int l1, input int l0);
    return {l4[1:0], l3[1:0], l2[1:0], l1[1:0], l0[1:0]};
  endfunction

  // monitor: compare one expected item per edge, just after the edge
  always @(posedge clk) begin
    #1;
    if (sbQ.size() > 0) begin
      expItem_t it;
      it = sbQ.pop_front();
      cmp(grant, it.g, it.tag, "grant");
      cmp(periphAck, it.a, it.tag, "ack");
    end
  end

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; chReq = 5'b11111; chEnable = 5'b11111; xferDone = 1'b0;
    chLevel = '0;
    repeat (3) @(posedge clk);
    #1;
    cmp(grant, 5'b0, "R1", "grant in reset");
    cmp(periphAck, 5'b0, "R1", "ack in reset");
    @(negedge clk);
    chReq = 5'b0; rstN = 1'b1;
    sbQ.push_back('{g:5'b0, a:5'b0, tag:"R1"});

    cyc(5'b00000, 5'b11111, 0, 5'b0, 5'b0, "R2 idle");
    cyc(5'b00001, 5'b11110, 0, 5'b0, 5'b0, "R3 disabled only");
    cyc(5'b00000, 5'b11111, 1, 5'b0, 5'b0, "R7 stray done");
    cyc(5'b00000, 5'b11111, 0, 5'b0, 5'b0, "R7 after stray");
    // ties at level 0
    cyc(5'b10110, 5'b11111, 0, 5'b00010, 5'b0, "R5 tie low index");
    @(negedge clk) chLevel = lv(3, 3, 3, 0, 3);
    sbQ.push_back('{g:5'b00010, a:5'b0, tag:"R6 level change"});
    cyc(5'b11111, 5'b11111, 0, 5'b00010, 5'b0, "R6 hold");
    cyc(5'b11111, 5'b11111, 1, 5'b00000, 5'b00010, "R8 done ack");
    chLevel = '0;
    cyc(5'b11111, 5'b11111, 0, 5'b00001, 5'b0, "R9 R10 next channel");
    cyc(5'b11111, 5'b11111, 1, 5'b00000, 5'b00001, "R8 ack ch0");
    cyc(5'b11111, 5'b11111, 0, 5'b00100, 5'b0, "R10 skip served");
    cyc(5'b11111, 5'b11111, 1, 5'b00000, 5'b00100, "R8 ack ch2");
    cyc(5'b00000, 5'b11111, 0, 5'b0, 5'b0, "R2 all dropped");
    // R4: level beats index
    chLevel = lv(3, 0, 0, 2, 0);
    cyc(5'b10011, 5'b11111, 0, 5'b10000, 5'b0, "R4 very high wins");
    cyc(5'b10011, 5'b11111, 1, 5'b00000, 5'b10000, "R8 ack ch4");
    cyc(5'b00000, 5'b11111, 0, 5'b0, 5'b0, "R2 drop");
    cyc(5'b00011, 5'b11111, 0, 5'b00010, 5'b0, "R4 high over low");
    cyc(5'b00011, 5'b11111, 1, 5'b00000, 5'b00010, "R8 ack ch1");
    cyc(5'b00000, 5'b11111, 0, 5'b0, 5'b0, "R2 drop");
    // R3: disabled top-level channel loses
    chLevel = lv(0, 0, 0, 3, 0);
    cyc(5'b00011, 5'b11101, 0, 5'b00001, 5'b0, "R3 disabled top level");
    cyc(5'b00011, 5'b11101, 1, 5'b00000, 5'b00001, "R8 ack ch0");
    // R10: held request after ack blocks, drop then re-raise
    cyc(5'b00001, 5'b11111, 0, 5'b0, 5'b0, "R10 still high");
    cyc(5'b00001, 5'b11111, 0, 5'b0, 5'b0, "R10 still high 2");
    cyc(5'b00000, 5'b11111, 0, 5'b0, 5'b0, "R10 dropped");
    cyc(5'b00001, 5'b11111, 0, 5'b00001, 5'b0, "R10 reraised");
    cyc(5'b00001, 5'b00000, 0, 5'b00001, 5'b0, "R6 enable drop holds");
    cyc(5'b00000, 5'b11111, 1, 5'b00000, 5'b00001, "R8 final ack");
    cyc(5'b00000, 5'b11111, 0, 5'b0, 5'b0, "R2 final idle");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule